// File: doc/BRIEF.md
# Synchronous SRAM Access Datapath

This block is the read and write path of a single-port synchronous static RAM. It samples the address, chip select, write controls and write data on each rising clock edge. A write can go to a chosen subset of byte lanes, or to the whole word at once. Each lane is nine bits wide, so the word can carry one parity bit for each byte. The storage is a small array of registers sized by parameters. Burst address generation is not part of the block, so the caller supplies every address.

Read data reaches the bus in one of two ways, selected by a strap input. With the strap low, the word goes straight from the array to the bus in the cycle after the sampling edge. With the strap high, the word passes through an extra output register and arrives one edge later. Deselects and writes move through the same pipeline as reads, so in registered mode the bus keeps driving for one full cycle after a deselect edge and turns off only after the following edge. Output enable and sleep act on the bus at once, without waiting for the clock. While sleep is high the block does no work and holds everything it stores.

Top module: `sram_path`

## Requirements
- R1: With `reg_mode` low, a read sampled at a rising edge (`cs`=1, `glob_wr`=0, `byte_wr_en`=0) drives the stored word on `rdata` with `bus_drv`=1 until the next edge, provided `oe`=1 and `sleep`=0.
- R2: With `reg_mode` high, read data and `bus_drv`=1 appear one edge later than in R1. After the sampling edge itself the bus still shows the previous cycle's state.
- R3: When `byte_wr_en`=1 and `glob_wr`=0, lane i (bits `wdata[i*LANE_W +: LANE_W]`) is written only if `byte_sel[i]`=1. The other lanes keep their contents. If `byte_sel` is all zero, nothing is written.
- R4: When `glob_wr`=1, every lane is written, whatever the values of `byte_wr_en` and `byte_sel`.
- R5: With `reg_mode` high, a deselect (`cs`=0) sampled at edge k leaves the bus driven with the earlier read's data through the cycle after edge k. `bus_drv` is 0 after edge k+1.
- R6: With `reg_mode` low, a deselect sampled at edge k makes `bus_drv`=0 right after edge k.
- R7: A write cycle never drives the bus. It turns the bus off with the same pipeline timing as a deselect.
- R8: While `oe`=0, `bus_drv`=0 and `rdata`=0 at once, with no clock edge needed. Raising `oe` again shows the pending read data.
- R9: While `sleep`=1, `bus_drv`=0 at once and no edge writes the array or advances the pipeline. Stored words survive the sleep period.
- R10: A read of an address in the cycle right after a write to it returns the newly written word.
- R11: After reset, `bus_drv`=0 and `rdata`=0. Whenever the bus is not driven, `rdata` reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset for the output pipeline |
| reg_mode | input | 1 | Output timing strap: 1 registered, 0 flow-through |
| cs | input | 1 | Chip select, sampled; 0 is a deselect |
| addr | input | AW | Word address, sampled |
| glob_wr | input | 1 | Write all lanes |
| byte_wr_en | input | 1 | Write the lanes picked by byte_sel |
| byte_sel | input | LANES | Per-lane write select |
| wdata | input | DW | Write data, LANE_W bits per lane |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous low-power hold |
| bus_drv | output | 1 | Data bus is being driven |
| rdata | output | DW | Read data, 0 when not driven |

## Verification
Three events can meet in the same cycle. A deselect or write can be sampled while the bus is still showing data from an earlier read, and the asynchronous controls can change in the middle of a cycle while a read is pending. The bench sends back-to-back read, read, deselect and read, write streams in registered mode, and samples at each falling edge to confirm the bus stays on for exactly one more cycle and then turns off. It also toggles `oe`, and holds `sleep` high during a global write with a read in flight. After each of these it checks the bus at once, and it reads the target address after the sleep ends to confirm the write never took place.

// File: rtl/sram_path.sv
module sram_path #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 16,
  localparam int DW = LANES * LANE_W,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_mode,
  input  logic             cs,
  input  logic [AW-1:0]    addr,
  input  logic             glob_wr,
  input  logic             byte_wr_en,
  input  logic [LANES-1:0] byte_sel,
  input  logic [DW-1:0]    wdata,
  input  logic             oe,
  input  logic             sleep,
  output logic             bus_drv,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0]    mem [DEPTH];
  logic [LANES-1:0] lane_we;
  logic             rd_cmd;
  logic             s1_rd, s2_rd;
  logic [AW-1:0]    s1_addr;
  logic [DW-1:0]    flow_q, s2_data;

  assign lane_we = glob_wr ? '1 : (byte_wr_en ? byte_sel : '0);
  assign rd_cmd  = cs & ~glob_wr & ~byte_wr_en;

  always_ff @(posedge clk) begin
    if (!sleep && cs) begin
      for (int i = 0; i < LANES; i++) begin
        if (lane_we[i]) mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_rd <= 1'b0;
      s2_rd <= 1'b0;
    end else if (!sleep) begin
      s1_rd <= rd_cmd;
      s2_rd <= s1_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (!sleep) begin
      s1_addr <= addr;
      s2_data <= flow_q;
    end
  end

  assign flow_q  = mem[s1_addr];
  assign bus_drv = oe & ~sleep & (reg_mode ? s2_rd : s1_rd);
  assign rdata   = bus_drv ? (reg_mode ? s2_data : flow_q) : '0;

endmodule

// File: rtl/sram_path_chk.sv
module sram_path_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 16,
  localparam int DW = LANES * LANE_W,
  localparam int AW = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_mode,
  input logic             cs,
  input logic [AW-1:0]    addr,
  input logic             glob_wr,
  input logic             byte_wr_en,
  input logic [LANES-1:0] byte_sel,
  input logic [DW-1:0]    wdata,
  input logic             oe,
  input logic             sleep,
  input logic             bus_drv,
  input logic [DW-1:0]    rdata
);

  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) !oe |-> !bus_drv);

  // R9
  sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) sleep |-> !bus_drv);

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !bus_drv |-> rdata == '0);

  // R5
  dcd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode && !cs && !sleep) |=> ##1 (!reg_mode || !bus_drv));

  // R7
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_mode && cs && (glob_wr || byte_wr_en) && !sleep) |=> (reg_mode || !bus_drv));

  // R1
  flow_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_mode && cs && !glob_wr && !byte_wr_en && !sleep) |=> (reg_mode || !oe || sleep || bus_drv));

endmodule

bind sram_path sram_path_chk #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_sram_path.sv
module sim_sram_path;
  localparam int CLK_P = 10;
  localparam int LANES = 2;
  localparam int LANE_W = 9;
  localparam int DEPTH = 16;
  localparam int DW = LANES * LANE_W;
  localparam int AW = $clog2(DEPTH);
  localparam int NV = 12;

  // {cs, glob_wr, byte_wr_en, byte_sel[1:0], addr[3:0], wdata[17:0], exp_drv, exp_data[17:0]}
  localparam logic [45:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 2'b00, 4'd1, 18'h31234, 1'b0, 18'h00000},
    {1'b1, 1'b0, 1'b0, 2'b00, 4'd1, 18'h00000, 1'b1, 18'h31234},
    {1'b1, 1'b0, 1'b1, 2'b01, 4'd1, 18'h00055, 1'b0, 18'h00000},
    {1'b1, 1'b0, 1'b0, 2'b00, 4'd1, 18'h00000, 1'b1, 18'h31255},
    {1'b1, 1'b0, 1'b1, 2'b00, 4'd1, 18'h3FFFF, 1'b0, 18'h00000},
    {1'b1, 1'b0, 1'b0, 2'b00, 4'd1, 18'h00000, 1'b1, 18'h31255},
    {1'b1, 1'b1, 1'b1, 2'b00, 4'd2, 18'h2ABCD, 1'b0, 18'h00000},
    {1'b1, 1'b0, 1'b0, 2'b00, 4'd2, 18'h00000, 1'b1, 18'h2ABCD},
    {1'b1, 1'b0, 1'b1, 2'b10, 4'd2, 18'h3FE00, 1'b0, 18'h00000},
    {1'b1, 1'b0, 1'b0, 2'b00, 4'd2, 18'h00000, 1'b1, 18'h3FFCD},
    {1'b0, 1'b0, 1'b0, 2'b00, 4'd1, 18'h00000, 1'b0, 18'h00000},
    {1'b1, 1'b0, 1'b0, 2'b00, 4'd1, 18'h00000, 1'b1, 18'h31255}
  };

  logic clk = 1'b0, rst_n = 1'b0, reg_mode = 1'b1, cs = 1'b0;
  logic [AW-1:0] addr = '0;
  logic glob_wr = 1'b0, byte_wr_en = 1'b0, oe = 1'b1, sleep = 1'b0;
  logic [LANES-1:0] byte_sel = '0;
  logic [DW-1:0] wdata = '0;
  logic bus_drv;
  logic [DW-1:0] rdata;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  sram_path #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input string tag, input logic ed, input logic [DW-1:0] ev);
    total++;
    if (bus_drv !== ed || rdata !== ev) begin
      bad++;
      $display("FAIL %s: drv=%0b data=%h expected drv=%0b data=%h", tag, bus_drv, rdata, ed, ev);
    end
  endtask

  task automatic cmd(input logic c, input logic g, input logic b, input logic [1:0] s,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    cs = c; glob_wr = g; byte_wr_en = b; byte_sel = s; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a); cmd(1'b1, 1'b0, 1'b0, 2'b00, a, '0); endtask
  task automatic idle(); cmd(1'b0, 1'b0, 1'b0, 2'b00, '0, '0); endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset", 1'b0, '0);
    rst_n = 1'b1;
    reg_mode = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      cmd(VEC[i][45], VEC[i][44], VEC[i][43], VEC[i][42:41], VEC[i][40:37], VEC[i][36:19]);
      chk($sformatf("R1/R3/R4/R6/R7/R10 vec %0d", i), VEC[i][18], VEC[i][17:0]);
    end

    idle();
    reg_mode = 1'b1;
    idle(); idle();
    rd(4'd1);  chk("R2 not yet", 1'b0, '0);
    rd(4'd2);  chk("R2 first", 1'b1, 18'h31255);
    idle();    chk("R5 held", 1'b1, 18'h3FFCD);
    idle();    chk("R5 off", 1'b0, '0);

    rd(4'd1);
    cmd(1'b1, 1'b1, 1'b0, 2'b00, 4'd3, 18'h12345); chk("R7 prior read", 1'b1, 18'h31255);
    idle();    chk("R7 write off", 1'b0, '0);
    rd(4'd3);
    idle();    chk("R10 pipelined", 1'b1, 18'h12345);

    rd(4'd2);
    rd(4'd2);  chk("R8 on", 1'b1, 18'h3FFCD);
    oe = 1'b0; #1; chk("R8 async off", 1'b0, '0);
    oe = 1'b1; #1; chk("R8 back", 1'b1, 18'h3FFCD);

    sleep = 1'b1; #1; chk("R9 async off", 1'b0, '0);
    cmd(1'b1, 1'b1, 1'b0, 2'b00, 4'd2, 18'h00000);
    cmd(1'b1, 1'b1, 1'b0, 2'b00, 4'd2, 18'h00000);
    chk("R9 asleep", 1'b0, '0);
    cs = 1'b0; glob_wr = 1'b0;
    sleep = 1'b0; #1; chk("R9 pipeline held", 1'b1, 18'h3FFCD);
    idle(); idle();
    rd(4'd2);
    idle();    chk("R9 contents kept", 1'b1, 18'h3FFCD);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule